// File: doc/BRIEF.md
# Keyed-Hash Key Prefix Sequencer

This block sits between a message FIFO and a sponge-based hash engine. In plain hash mode it is transparent: the FIFO's valid, data and byte strobe go straight to the engine, the engine's ready goes straight back, and the caller's process request is forwarded untouched. When keyed mode is enabled and a start pulse arrives, the block first emits one full rate-sized block that carries the secret key. The block is formatted as bytepad(encode_string(key), rate). While that block is being sent, the FIFO is held off. Once the last key word has been accepted, the message stream is passed through again.

A five-state controller orders the work. The states are idle, key injection, message, flush (waiting for the engine to finish) and a terminal error trap. In keyed mode the block generates its own process pulse. A process request that arrives before that pulse can be given is remembered and released on the first message cycle. Completion and escalation use four-bit redundant encodings, so that a single upset cannot fake either one.

Top module: `keypfx_seq`

## Requirements
- R1: While reset is held, and after it is released, the block is idle and passes through. eng_valid equals fifo_valid, eng_data equals fifo_data, eng_strb equals fifo_strb and fifo_ready equals eng_ready.
- R2: Key injection begins on the clock edge after a cycle in which kmac_en and start are both 1. start without kmac_en, or kmac_en without start, leaves the block passing through.
- R3: During key injection, eng_valid is 1, eng_strb is all ones and fifo_ready is 0. The words carry, byte 0 in bits [7:0] of each word: 0x01, the rate in bytes, then the key bit length encoded as count byte followed by big-endian value (0x01,L for lengths under 256; 0x02,hi,lo otherwise), then the key bytes (key_words bits [7:0] first), then zeros. Exactly rate/(DW/8) words are sent.
- R4: key_len_sel codes 0,1,2,3,4 select key lengths of 128, 192, 256, 384 and 512 bits. Any other code selects 128 bits.
- R5: strength_sel codes 0,1,2,3,4 select rates of 168, 144, 136, 104 and 72 bytes. Any other code selects 168 bytes.
- R6: A key word advances only on a cycle with eng_ready at 1. While eng_ready is 0, the same word is held.
- R7: After the last key word is accepted, the block passes the FIFO through. A process_req in that message phase gives a one-cycle process_out pulse in the same cycle and moves the block to flush.
- R8: In keyed mode, a process_req seen while process_out is 0 is remembered. It yields process_out on the first message cycle. Seeing a true done code discards it.
- R9: In flush, only done_mb = 4'b0110 returns the block to idle. Every other done code, and any start, is ignored.
- R10: With kmac_en at 0, process_out equals process_req.
- R11: Any escalate_mb value other than 4'b1001 moves the block, from any state, into a trap. The trap ends key injection at once, never starts it again, and keeps process_out at 0 in keyed mode until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kmac_en | input | 1 | Keyed mode enable |
| start | input | 1 | Start of a hash operation |
| process_req | input | 1 | End-of-message request from the caller |
| done_mb | input | 4 | Engine completion, 4'b0110 means done |
| escalate_mb | input | 4 | Escalation, 4'b1001 means inactive |
| key_len_sel | input | 3 | Key length code |
| strength_sel | input | 3 | Security strength code |
| key_words | input | 512 | Key bytes, first byte in bits [7:0] |
| fifo_valid | input | 1 | Message FIFO valid |
| fifo_data | input | DW | Message FIFO data |
| fifo_strb | input | DW/8 | Message FIFO byte strobe |
| fifo_ready | output | 1 | Ready returned to the FIFO |
| eng_valid | output | 1 | Valid toward the engine |
| eng_data | output | DW | Data toward the engine |
| eng_strb | output | DW/8 | Byte strobe toward the engine |
| eng_ready | input | 1 | Ready from the engine |
| process_out | output | 1 | Process pulse forwarded to the engine |

## Verification
The bench builds the block with the default 64-bit word width. At that width every rate maps to a whole number of words, from 9 words at the 72-byte rate to 21 words at the 168-byte rate. This brings the last-word comparison, and the point where the header stops and the key bytes start, into reach for all five strengths and all five key lengths. The 256-bit key length exercises the three-byte length header, and shorter keys exercise the two-byte form. Both out-of-range codes are also run. The key blocks are sent with and without engine back-pressure, so the index hold at a stall and a process request latched mid-injection both get exercised.

// File: rtl/keypfx_pkg.sv
package keypfx_pkg;

  localparam int unsigned KEY_MAX_W  = 512;
  localparam int unsigned KEY_MAX_B  = KEY_MAX_W / 8;
  localparam int unsigned HDR_MAX_B  = 5;
  localparam int unsigned RATE_MAX_B = 168;

  // redundant four-bit encodings
  localparam logic [3:0] MB_TRUE  = 4'b0110;
  localparam logic [3:0] MB_FALSE = 4'b1001;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_KEY   = 3'd1,
    ST_MSG   = 3'd2,
    ST_FLUSH = 3'd3,
    ST_ERR   = 3'd4
  } seq_st_e;

  // sponge rate in bytes per strength code
  function automatic logic [7:0] rate_bytes(input logic [2:0] sel);
    logic [7:0] r;
    case (sel)
      3'd1:    r = 8'd144;
      3'd2:    r = 8'd136;
      3'd3:    r = 8'd104;
      3'd4:    r = 8'd72;
      default: r = 8'd168;
    endcase
    return r;
  endfunction

  // key length in bits per key length code
  function automatic logic [9:0] key_bits(input logic [2:0] sel);
    logic [9:0] k;
    case (sel)
      3'd1:    k = 10'd192;
      3'd2:    k = 10'd256;
      3'd3:    k = 10'd384;
      3'd4:    k = 10'd512;
      default: k = 10'd128;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/keypfx_ctrl.sv
module keypfx_ctrl
  import keypfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       kmac_en,
  input  logic       start,
  input  logic       process_req,
  input  logic [3:0] done_mb,
  input  logic [3:0] escalate_mb,
  input  logic       key_last,
  output seq_st_e    st_o,
  output logic       process_out
);

  seq_st_e st_q, st_d;
  logic    pend_q;
  logic    esc_on, done_on, int_proc;

  assign esc_on   = (escalate_mb != MB_FALSE);
  assign done_on  = (done_mb == MB_TRUE);
  assign int_proc = (st_q == ST_MSG) && (process_req || pend_q);

  assign process_out = kmac_en ? int_proc : process_req;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (kmac_en && start)           st_d = ST_KEY;
      ST_KEY:   if (key_last)                   st_d = ST_MSG;
      ST_MSG:   if (process_req || pend_q)      st_d = ST_FLUSH;
      ST_FLUSH: if (done_on)                    st_d = ST_IDLE;
      ST_ERR:                                   st_d = ST_ERR;
      default:                                  st_d = ST_ERR;
    endcase
    if (esc_on) st_d = ST_ERR;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  // remembered process request
  always_ff @(posedge clk) begin
    if (rst)                            pend_q <= 1'b0;
    else if (process_req && !process_out) pend_q <= 1'b1;
    else if (process_out || done_on)    pend_q <= 1'b0;
  end

  assign st_o = st_q;

endmodule

// File: rtl/keypfx_keygen.sv
module keypfx_keygen
  import keypfx_pkg::*;
#(
  parameter  int unsigned DW    = 64,
  localparam int unsigned SB    = DW / 8,
  localparam int unsigned IDX_W = $clog2(RATE_MAX_B * 8 / DW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 eng_ready,
  input  logic [2:0]           key_len_sel,
  input  logic [2:0]           strength_sel,
  input  logic [KEY_MAX_W-1:0] key_words,
  output logic [DW-1:0]        key_data,
  output logic [SB-1:0]        key_strb,
  output logic                 key_last,
  output logic [IDX_W-1:0]     idx_o
);

  localparam int unsigned PFX_W = (HDR_MAX_B + KEY_MAX_B) * 8;

  logic [7:0]                rate;
  logic [9:0]                kbits;
  logic [IDX_W-1:0]          idx_q, limit;
  logic [KEY_MAX_W-1:0]      kmask;
  logic [HDR_MAX_B*8-1:0]    hdr;
  logic [2:0]                hdr_len;
  logic [PFX_W-1:0]          pfx, shifted;

  assign rate  = rate_bytes(strength_sel);
  assign kbits = key_bits(key_len_sel);
  assign limit = IDX_W'((32'(rate) * 32'd8) / DW - 32'd1);

  always_ff @(posedge clk) begin
    if (rst || !active) idx_q <= '0;
    else if (eng_ready) idx_q <= idx_q + 1'b1;
  end

  assign key_last = active && eng_ready && (idx_q == limit);

  // keep only the bytes inside the selected key length
  for (genvar b = 0; b < KEY_MAX_B; b++) begin : g_mask
    assign kmask[b*8 +: 8] = (32'(b) < (32'(kbits) / 32'd8)) ? 8'hFF : 8'h00;
  end

  // rate and key length encodings, lowest byte first
  always_comb begin
    if (kbits < 10'd256) begin
      hdr     = {8'h00, kbits[7:0], 8'h01, rate, 8'h01};
      hdr_len = 3'd4;
    end else begin
      hdr     = {kbits[7:0], {6'b0, kbits[9:8]}, 8'h02, rate, 8'h01};
      hdr_len = 3'd5;
    end
  end

  assign pfx     = (PFX_W'(key_words & kmask) << (32'(hdr_len) * 32'd8)) | PFX_W'(hdr);
  assign shifted = pfx >> (32'(idx_q) * DW);

  assign key_data = active ? shifted[DW-1:0] : '0;
  assign key_strb = active ? '1 : '0;
  assign idx_o    = idx_q;

endmodule

// File: rtl/keypfx_mux.sv
module keypfx_mux #(
  parameter  int unsigned DW = 64,
  localparam int unsigned SB = DW / 8
) (
  input  logic          key_sel,
  input  logic [DW-1:0] key_data,
  input  logic [SB-1:0] key_strb,
  input  logic          fifo_valid,
  input  logic [DW-1:0] fifo_data,
  input  logic [SB-1:0] fifo_strb,
  input  logic          eng_ready,
  output logic          fifo_ready,
  output logic          eng_valid,
  output logic [DW-1:0] eng_data,
  output logic [SB-1:0] eng_strb
);

  assign eng_valid  = key_sel ? 1'b1     : fifo_valid;
  assign eng_data   = key_sel ? key_data : fifo_data;
  assign eng_strb   = key_sel ? key_strb : fifo_strb;
  assign fifo_ready = key_sel ? 1'b0     : eng_ready;

endmodule

// File: rtl/keypfx_seq.sv
module keypfx_seq
  import keypfx_pkg::*;
#(
  parameter  int unsigned DW    = 64,
  localparam int unsigned SB    = DW / 8,
  localparam int unsigned IDX_W = $clog2(RATE_MAX_B * 8 / DW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 kmac_en,
  input  logic                 start,
  input  logic                 process_req,
  input  logic [3:0]           done_mb,
  input  logic [3:0]           escalate_mb,
  input  logic [2:0]           key_len_sel,
  input  logic [2:0]           strength_sel,
  input  logic [KEY_MAX_W-1:0] key_words,
  input  logic                 fifo_valid,
  input  logic [DW-1:0]        fifo_data,
  input  logic [SB-1:0]        fifo_strb,
  output logic                 fifo_ready,
  output logic                 eng_valid,
  output logic [DW-1:0]        eng_data,
  output logic [SB-1:0]        eng_strb,
  input  logic                 eng_ready,
  output logic                 process_out
);

  seq_st_e          st;
  logic             key_sel, key_last;
  logic [DW-1:0]    key_data;
  logic [SB-1:0]    key_strb;
  logic [IDX_W-1:0] key_idx;

  assign key_sel = (st == ST_KEY);

  keypfx_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .kmac_en     (kmac_en),
    .start       (start),
    .process_req (process_req),
    .done_mb     (done_mb),
    .escalate_mb (escalate_mb),
    .key_last    (key_last),
    .st_o        (st),
    .process_out (process_out)
  );

  keypfx_keygen #(.DW(DW)) u_keygen (
    .clk          (clk),
    .rst          (rst),
    .active       (key_sel),
    .eng_ready    (eng_ready),
    .key_len_sel  (key_len_sel),
    .strength_sel (strength_sel),
    .key_words    (key_words),
    .key_data     (key_data),
    .key_strb     (key_strb),
    .key_last     (key_last),
    .idx_o        (key_idx)
  );

  keypfx_mux #(.DW(DW)) u_mux (
    .key_sel    (key_sel),
    .key_data   (key_data),
    .key_strb   (key_strb),
    .fifo_valid (fifo_valid),
    .fifo_data  (fifo_data),
    .fifo_strb  (fifo_strb),
    .eng_ready  (eng_ready),
    .fifo_ready (fifo_ready),
    .eng_valid  (eng_valid),
    .eng_data   (eng_data),
    .eng_strb   (eng_strb)
  );

endmodule

// File: rtl/keypfx_seq_chk.sv
module keypfx_seq_chk
  import keypfx_pkg::*;
#(
  parameter  int unsigned DW    = 64,
  localparam int unsigned IDX_W = $clog2(RATE_MAX_B * 8 / DW)
) (
  input logic             clk,
  input logic             rst,
  input seq_st_e          st,
  input logic [IDX_W-1:0] key_idx,
  input logic             kmac_en,
  input logic             start,
  input logic [3:0]       done_mb,
  input logic [3:0]       escalate_mb,
  input logic             eng_ready,
  input logic             eng_valid,
  input logic             fifo_ready,
  input logic             process_out
);

  logic calm;
  assign calm = (escalate_mb == MB_FALSE);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !(kmac_en && start) && calm) |=> (st == ST_IDLE)); // R2

  AST_IDLE_GO: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && kmac_en && start && calm) |=> (st == ST_KEY)); // R2

  AST_KEY_GATE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_KEY) |-> (eng_valid && !fifo_ready)); // R3

  AST_KEY_STALL: assert property (@(posedge clk) disable iff (rst)
    (st == ST_KEY && !eng_ready && calm) |=> (st == ST_KEY && $stable(key_idx))); // R6

  AST_PROC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (kmac_en && process_out) |=> !(kmac_en && process_out)); // R7

  AST_FLUSH_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FLUSH && done_mb != MB_TRUE && calm) |=> (st == ST_FLUSH)); // R9

  AST_ESC_TRAP: assert property (@(posedge clk) disable iff (rst)
    !calm |=> (st == ST_ERR)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERR) |=> (st == ST_ERR)); // R11

endmodule

bind keypfx_seq keypfx_seq_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st          (st),
  .key_idx     (key_idx),
  .kmac_en     (kmac_en),
  .start       (start),
  .done_mb     (done_mb),
  .escalate_mb (escalate_mb),
  .eng_ready   (eng_ready),
  .eng_valid   (eng_valid),
  .fifo_ready  (fifo_ready),
  .process_out (process_out)
);

// File: tb/keypfx_seq_tb.sv
module keypfx_seq_tb;
  import keypfx_pkg::*;

  localparam int unsigned DW = 64;
  localparam int unsigned SB = DW / 8;

  logic           clk = 1'b0;
  logic           rst;
  logic           kmac_en, start, process_req;
  logic [3:0]     done_mb, escalate_mb;
  logic [2:0]     key_len_sel, strength_sel;
  logic [511:0]   key_words;
  logic           fifo_valid;
  logic [DW-1:0]  fifo_data;
  logic [SB-1:0]  fifo_strb;
  logic           fifo_ready, eng_valid, eng_ready, process_out;
  logic [DW-1:0]  eng_data;
  logic [SB-1:0]  eng_strb;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  keypfx_seq #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .kmac_en(kmac_en), .start(start),
    .process_req(process_req), .done_mb(done_mb), .escalate_mb(escalate_mb),
    .key_len_sel(key_len_sel), .strength_sel(strength_sel), .key_words(key_words),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_strb(fifo_strb),
    .fifo_ready(fifo_ready), .eng_valid(eng_valid), .eng_data(eng_data),
    .eng_strb(eng_strb), .eng_ready(eng_ready), .process_out(process_out)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic logic [511:0] mk_key(input logic [7:0] seed);
    logic [511:0] k;
    for (int i = 0; i < 64; i++) k[i*8 +: 8] = seed + 8'(i * 7);
    return k;
  endfunction

  // expected key block word, built byte by byte from R3
  function automatic logic [DW-1:0] exp_word(input int idx, input int kbits,
                                             input int rate, input logic [511:0] key);
    logic [7:0]    bb [RATE_MAX_B];
    logic [DW-1:0] w;
    int            p;
    for (int i = 0; i < int'(RATE_MAX_B); i++) bb[i] = 8'h00;
    bb[0] = 8'h01;
    bb[1] = rate[7:0];
    if (kbits < 256) begin
      bb[2] = 8'h01; bb[3] = kbits[7:0]; p = 4;
    end else begin
      bb[2] = 8'h02; bb[3] = kbits[15:8]; bb[4] = kbits[7:0]; p = 5;
    end
    for (int i = 0; i < kbits / 8; i++) bb[p + i] = key[i*8 +: 8];
    w = '0;
    for (int j = 0; j < int'(SB); j++) w[j*8 +: 8] = bb[idx * int'(SB) + j];
    return w;
  endfunction

  // scoreboard monitor: every accepted key word is compared with the queue
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (!rst && eng_valid && eng_ready && !fifo_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R3 extra key word: actual=%h expected=none", eng_data);
        end else begin
          check("R3 key word", eng_data, exp_q.pop_front());
          check("R3 key strobe", DW'(eng_strb), DW'({SB{1'b1}}));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  task automatic run_key(input logic [2:0] lsel, input logic [2:0] ssel, input int kbits,
                         input int rate, input logic [511:0] key, input bit stall,
                         input bit late_proc);
    for (int i = 0; i < rate / int'(SB); i++) exp_q.push_back(exp_word(i, kbits, rate, key));
    @(negedge clk);
    kmac_en = 1'b1; start = 1'b1; key_len_sel = lsel; strength_sel = ssel;
    key_words = key; eng_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #2;
    check("R3 fifo held off", DW'(fifo_ready), '0);
    check("R3 key valid", DW'(eng_valid), 1);
    for (int it = 1; it < 200; it++) begin
      @(negedge clk);
      if (exp_q.size() == 0) break;
      eng_ready   = stall ? it[0] : 1'b1;
      process_req = late_proc && (it == 3);
      if (late_proc && it == 3) begin
        #2 check("R8 no pulse during key", DW'(process_out), '0);
      end
    end
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R6 key block stuck: actual=%0d expected=0 words left", exp_q.size());
      exp_q.delete();
    end
    eng_ready = 1'b1; process_req = 1'b0;
    #2;
    check("R7 fifo ready back", DW'(fifo_ready), 1);
    check("R7 fifo data through", eng_data, fifo_data);
    check("R8 first message cycle pulse", DW'(process_out), DW'(late_proc));
  endtask

  task automatic finish_msg(input bit pulse, input bit bad_done, input bit stale);
    if (pulse) begin
      @(negedge clk); process_req = 1'b1;
      #2 check("R7 process pulse", DW'(process_out), 1);
      @(negedge clk); process_req = 1'b0;
      #2 check("R7 pulse single cycle", DW'(process_out), '0);
    end else begin
      @(negedge clk);
    end
    if (stale) begin
      @(negedge clk); process_req = 1'b1;
      #2 check("R8 no pulse in flush", DW'(process_out), '0);
      @(negedge clk); process_req = 1'b0;
    end
    if (bad_done) begin
      @(negedge clk); done_mb = 4'b1110;
      @(negedge clk); done_mb = MB_FALSE; start = 1'b1; kmac_en = 1'b1;
      @(negedge clk); start = 1'b0;
      #2 check("R9 loose done and start ignored", DW'(fifo_ready), 1);
    end
    @(negedge clk); done_mb = MB_TRUE;
    @(negedge clk); done_mb = MB_FALSE;
  endtask

  initial begin
    rst = 1'b1; kmac_en = 1'b0; start = 1'b0; process_req = 1'b0;
    done_mb = MB_FALSE; escalate_mb = MB_FALSE; key_len_sel = '0; strength_sel = '0;
    key_words = '0; fifo_valid = 1'b1; fifo_data = 64'hA5A5_0000_1234_5678;
    fifo_strb = 8'h3C; eng_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R1 data through", eng_data, fifo_data);
    check("R1 strobe through", DW'(eng_strb), DW'(fifo_strb));
    check("R1 ready through", DW'(fifo_ready), 1);
    check("R1 valid through", DW'(eng_valid), 1);
    check("R1 no process", DW'(process_out), '0);

    @(negedge clk); process_req = 1'b1;
    #2 check("R10 raw process forwarded", DW'(process_out), 1);
    @(negedge clk); process_req = 1'b0; start = 1'b1; eng_ready = 1'b0;
    #2 check("R1 ready follows engine", DW'(fifo_ready), '0);
    @(negedge clk); start = 1'b0; eng_ready = 1'b1;
    #2 check("R2 start without enable", DW'(fifo_ready), 1);
    @(negedge clk); kmac_en = 1'b1;
    @(negedge clk);
    #2 check("R2 enable without start", DW'(fifo_ready), 1);

    run_key(3'd0, 3'd0, 128, 168, mk_key(8'h11), 1'b0, 1'b0);   // R4 R5
    finish_msg(1'b1, 1'b1, 1'b0);
    run_key(3'd4, 3'd4, 512, 72, mk_key(8'h40), 1'b1, 1'b1);    // R6 R8
    finish_msg(1'b0, 1'b0, 1'b1);
    run_key(3'd1, 3'd1, 192, 144, mk_key(8'h83), 1'b0, 1'b0);   // R8 stale request cleared
    finish_msg(1'b1, 1'b0, 1'b0);
    run_key(3'd2, 3'd2, 256, 136, mk_key(8'hC7), 1'b1, 1'b0);
    finish_msg(1'b1, 1'b0, 1'b0);
    run_key(3'd3, 3'd3, 384, 104, mk_key(8'h05), 1'b0, 1'b0);
    finish_msg(1'b1, 1'b0, 1'b0);
    run_key(3'd7, 3'd6, 128, 168, mk_key(8'h9E), 1'b0, 1'b0);   // R4 R5 defaults
    finish_msg(1'b1, 1'b0, 1'b0);

    // R11: escalation during injection
    for (int i = 0; i < 9; i++) exp_q.push_back(exp_word(i, 128, 72, mk_key(8'h2A)));
    @(negedge clk);
    kmac_en = 1'b1; start = 1'b1; key_len_sel = 3'd0; strength_sel = 3'd4;
    key_words = mk_key(8'h2A);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk); escalate_mb = 4'b0000;
    @(negedge clk);
    #2;
    check("R11 injection stops", DW'(fifo_ready), 1);
    check("R11 fifo data through", eng_data, fifo_data);
    exp_q.delete();
    @(negedge clk); escalate_mb = MB_FALSE; start = 1'b1;
    @(negedge clk); start = 1'b0;
    #2 check("R11 trap ignores start", DW'(fifo_ready), 1);
    @(negedge clk); process_req = 1'b1;
    #2 check("R11 trap blocks process", DW'(process_out), '0);
    @(negedge clk); process_req = 1'b0;
    @(negedge clk);
    summary();
  end

endmodule